// File: doc/BRIEF.md
# Channel Terminal-Function Sequencer

This block decides what one I/O channel does when a transfer reaches a boundary. A data path next to it reports events: a word assembled with interlace off, the word count reaching zero, end of record from the device, an emptied output buffer, an output underrun, and a program request to terminate output. From the function code, the direction, the mode enables and the interrupt-system state, the sequencer raises single-cycle strobes for the interrupts (zero word count, end of word, end of record) and for error, disconnect, interlace clear, transfer-request drop and write-end-of-record. It also holds a level showing that a proceed function is between records.

The function code is three bits. Bit 2 clear means compatible mode. With bit 2 set, bit 1 selects signal (set) or record (clear) and bit 0 selects proceed (set) or disconnect (clear). The codes are 100 record/disconnect, 101 record/proceed, 110 signal/disconnect and 111 signal/proceed. Every strobe appears one clock after the event that causes it. In one cycle, end of record takes priority over count zero, and count zero takes priority over the word-level events. Moving data and counting addresses are handled outside this block.

Top module: `chan_term_seq`

## Requirements
- R1: While reset is held, and after it is released with no events, every strobe output and the inter-record level are low. Each strobe is a single-cycle pulse that appears one clock after its event.
- R2: Input direction, count zero: a non-compatible function (func bit 2 = 1) pulses zero-word-count when its enable is set. Compatible mode (bit 2 = 0) raises nothing.
- R3: Input direction, count zero with signal/disconnect (110): end-of-record is also pulsed when its enable is set, and disconnect is pulsed.
- R4: Input direction, word full with interlace off: compatible mode pulses end-of-word only when interrupts are on. A signal function (bit 1 = 1) pulses error. A record function (bit 1 = 0) discards the word and raises nothing.
- R5: End of record from the device pulses interlace-clear. It pulses end-of-record when the mode is compatible with interrupts on, or when the end-of-record enable is set.
- R6: After end of record, a proceed function (bit 2 = 1, bit 0 = 1) sets the inter-record level and does not disconnect. Every other function pulses disconnect. The level clears on the next word-full, buffer-empty or disconnect.
- R7: Output direction, count zero in compatible mode: zero-word-count is pulsed when interrupts are on, and disconnect is pulsed.
- R8: Output direction, count zero with a signal function: zero-word-count is pulsed when enabled. Code 110 also pulses end-of-record when enabled, and disconnect. Code 111 enters the inter-record state. Record functions raise nothing.
- R9: A terminate-output request on output while the buffer is busy or interlace is on is held pending. The next buffer-empty then pulses write-end-of-record instead of end-of-word and clears the pending request. With the channel idle, the request pulses write-end-of-record at once.
- R10: Output direction, buffer emptied with interlace off and nothing pending: end-of-word is pulsed only when interrupts are on.
- R11: Output underrun with interlace off pulses transfer-request drop and error. An underrun while interlace is on, or in the same cycle as end of record, raises neither.
- R12: A terminate-output request in the input direction is ignored. A later buffer-empty on output behaves as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_i | input | FN_W | Terminal function code |
| dir_out_i | input | 1 | 1 = output transfer, 0 = input |
| int_on_i | input | 1 | Interrupt system enabled |
| zwc_en_i | input | 1 | Zero-word-count interrupt enable |
| eor_en_i | input | 1 | End-of-record interrupt enable |
| ilce_i | input | 1 | Interlace active |
| buf_busy_i | input | 1 | Output buffer holds data |
| word_full_i | input | 1 | Input word full with interlace off |
| wc_zero_i | input | 1 | Word count reached zero |
| dev_eor_i | input | 1 | End of record from the device |
| buf_empty_i | input | 1 | Output buffer just emptied |
| underrun_i | input | 1 | Output demand with an empty buffer |
| top_req_i | input | 1 | Terminate-output request |
| zwc_int_o | output | 1 | Zero-word-count interrupt strobe |
| eow_int_o | output | 1 | End-of-word interrupt strobe |
| eor_int_o | output | 1 | End-of-record interrupt strobe |
| err_o | output | 1 | Error flag set strobe |
| disc_o | output | 1 | Disconnect strobe |
| wreor_o | output | 1 | Write-end-of-record request strobe |
| xfr_drop_o | output | 1 | Drop transfer request strobe |
| ilce_clr_o | output | 1 | Clear interlace strobe |
| interrec_o | output | 1 | Inter-record state level |

## Verification
The deferred terminate request is the hardest case to reach from the ports. The request must arrive while the buffer is busy. The bench then spends a quiet cycle in which nothing may appear. Only after that does it present a buffer-empty, where write-end-of-record must replace end-of-word, and a second buffer-empty must show that the pending state was cleared. The inter-record level is checked the same way: it is set by a proceed end-of-record or by a signal/proceed count-zero on output, held through idle cycles, and then cleared by the next word event.

// File: rtl/chan_tseq_pkg.sv
package chan_tseq_pkg;

   localparam int FN_W_MIN      = 3;
   localparam int FN_CHAN_BIT   = 2;
   localparam int FN_SIG_BIT    = 1;
   localparam int FN_PROC_BIT   = 0;

   typedef struct packed {
      logic compat;
      logic signal;
      logic proceed;
      logic sig_disc;
      logic sig_proc;
   } fn_dec_t;

   typedef struct packed {
      logic zwc;
      logic eow;
      logic eor;
      logic err;
      logic disc;
      logic wreor;
      logic drop;
      logic ilce_clr;
      logic set_ir;
   } act_t;

endpackage

// File: rtl/tseq_fn_decode.sv
module tseq_fn_decode
   import chan_tseq_pkg::*;
#(
   parameter int FN_W = 3
) (
   input  logic [FN_W-1:0] fn_i,
   output fn_dec_t         dec_o
);

   generate
      if (FN_W < FN_W_MIN) begin : g_bad_width
         $error("tseq_fn_decode: FN_W must be at least 3");
      end
   endgenerate

   always_comb begin
      dec_o          = '0;
      dec_o.compat   = !fn_i[FN_CHAN_BIT];
      dec_o.signal   = fn_i[FN_CHAN_BIT] && fn_i[FN_SIG_BIT];
      dec_o.proceed  = fn_i[FN_CHAN_BIT] && fn_i[FN_PROC_BIT];
      dec_o.sig_disc = dec_o.signal && !fn_i[FN_PROC_BIT];
      dec_o.sig_proc = dec_o.signal &&  fn_i[FN_PROC_BIT];
   end

endmodule

// File: rtl/tseq_top_pend.sv
module tseq_top_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_out_i,
   input  logic top_req_i,
   input  logic buf_busy_i,
   input  logic ilce_i,
   input  logic buf_empty_i,
   input  logic clr_i,
   output logic wreor_req_o,
   output logic pend_o
);

   logic pend_q;
   logic hold;
   logic issue_now;
   logic drain;

   assign hold      = dir_out_i && top_req_i && (buf_busy_i || ilce_i);
   assign issue_now = dir_out_i && top_req_i && !buf_busy_i && !ilce_i;
   assign drain     = dir_out_i && pend_q && buf_empty_i;

   assign wreor_req_o = issue_now || drain;
   assign pend_o      = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (hold) begin
         pend_q <= 1'b1;
      end else if (drain || clr_i) begin
         pend_q <= 1'b0;
      end
   end

   // R9
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !buf_empty_i && !clr_i) |=> pend_q);

endmodule

// File: rtl/tseq_action.sv
module tseq_action
   import chan_tseq_pkg::*;
(
   input  fn_dec_t dec_i,
   input  logic    dir_out_i,
   input  logic    int_on_i,
   input  logic    zwc_en_i,
   input  logic    eor_en_i,
   input  logic    ilce_i,
   input  logic    word_full_i,
   input  logic    wc_zero_i,
   input  logic    dev_eor_i,
   input  logic    buf_empty_i,
   input  logic    underrun_i,
   input  logic    pend_i,
   input  logic    wreor_req_i,
   output act_t    act_o
);

   always_comb begin
      act_o       = '0;
      act_o.wreor = wreor_req_i;
      if (dev_eor_i) begin
         act_o.ilce_clr = 1'b1;
         act_o.eor      = (dec_i.compat && int_on_i) || eor_en_i;
         if (dec_i.proceed) act_o.set_ir = 1'b1;
         else               act_o.disc   = 1'b1;
      end else if (wc_zero_i) begin
         if (!dir_out_i) begin
            act_o.zwc = !dec_i.compat && zwc_en_i;
            if (dec_i.sig_disc) begin
               act_o.eor  = eor_en_i;
               act_o.disc = 1'b1;
            end
         end else if (dec_i.compat) begin
            act_o.zwc  = int_on_i;
            act_o.disc = 1'b1;
         end else if (dec_i.signal) begin
            act_o.zwc = zwc_en_i;
            if (dec_i.sig_disc) begin
               act_o.eor  = eor_en_i;
               act_o.disc = 1'b1;
            end else begin
               act_o.set_ir = 1'b1;
            end
         end
      end else if (!dir_out_i) begin
         if (word_full_i) begin
            if (dec_i.compat)      act_o.eow = int_on_i;
            else if (dec_i.signal) act_o.err = 1'b1;
         end
      end else begin
         if (underrun_i && !ilce_i) begin
            act_o.drop = 1'b1;
            act_o.err  = 1'b1;
         end else if (buf_empty_i && !ilce_i && !pend_i) begin
            act_o.eow = int_on_i;
         end
      end
   end

endmodule

// File: rtl/chan_term_seq.sv
module chan_term_seq
   import chan_tseq_pkg::*;
#(
   parameter int FN_W    = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FN_W-1:0] func_i,
   input  logic            dir_out_i,
   input  logic            int_on_i,
   input  logic            zwc_en_i,
   input  logic            eor_en_i,
   input  logic            ilce_i,
   input  logic            buf_busy_i,
   input  logic            word_full_i,
   input  logic            wc_zero_i,
   input  logic            dev_eor_i,
   input  logic            buf_empty_i,
   input  logic            underrun_i,
   input  logic            top_req_i,
   output logic            zwc_int_o,
   output logic            eow_int_o,
   output logic            eor_int_o,
   output logic            err_o,
   output logic            disc_o,
   output logic            wreor_o,
   output logic            xfr_drop_o,
   output logic            ilce_clr_o,
   output logic            interrec_o
);

   fn_dec_t dec;
   act_t    act;
   logic    wreor_req;
   logic    pend;
   logic    ir_q;

   tseq_fn_decode #(.FN_W(FN_W)) u_dec (
      .fn_i  (func_i),
      .dec_o (dec)
   );

   tseq_top_pend u_pend (
      .clk         (clk),
      .rst_n       (rst_n),
      .dir_out_i   (dir_out_i),
      .top_req_i   (top_req_i),
      .buf_busy_i  (buf_busy_i),
      .ilce_i      (ilce_i),
      .buf_empty_i (buf_empty_i),
      .clr_i       (act.disc),
      .wreor_req_o (wreor_req),
      .pend_o      (pend)
   );

   tseq_action u_act (
      .dec_i       (dec),
      .dir_out_i   (dir_out_i),
      .int_on_i    (int_on_i),
      .zwc_en_i    (zwc_en_i),
      .eor_en_i    (eor_en_i),
      .ilce_i      (ilce_i),
      .word_full_i (word_full_i),
      .wc_zero_i   (wc_zero_i),
      .dev_eor_i   (dev_eor_i),
      .buf_empty_i (buf_empty_i),
      .underrun_i  (underrun_i),
      .pend_i      (pend),
      .wreor_req_i (wreor_req),
      .act_o       (act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q <= 1'b0;
      end else if (act.set_ir) begin
         ir_q <= 1'b1;
      end else if (act.disc || word_full_i || buf_empty_i) begin
         ir_q <= 1'b0;
      end
   end

   assign interrec_o = ir_q;

   generate
      if (REG_OUT) begin : g_reg_out
         act_t act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) act_q <= '0;
            else        act_q <= act;
         end
         assign zwc_int_o  = act_q.zwc;
         assign eow_int_o  = act_q.eow;
         assign eor_int_o  = act_q.eor;
         assign err_o      = act_q.err;
         assign disc_o     = act_q.disc;
         assign wreor_o    = act_q.wreor;
         assign xfr_drop_o = act_q.drop;
         assign ilce_clr_o = act_q.ilce_clr;

         // R2
         zwc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            zwc_int_o |-> $past(wc_zero_i));
         // R4
         eow_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eow_int_o |-> $past(int_on_i));
         // R6
         ir_no_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(interrec_o) |-> !disc_o);
         // R9
         wreor_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wreor_o |-> $past(dir_out_i));
         // R11
         drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
            xfr_drop_o |-> (err_o && !$past(ilce_i)));
      end else begin : g_comb_out
         assign zwc_int_o  = act.zwc;
         assign eow_int_o  = act.eow;
         assign eor_int_o  = act.eor;
         assign err_o      = act.err;
         assign disc_o     = act.disc;
         assign wreor_o    = act.wreor;
         assign xfr_drop_o = act.drop;
         assign ilce_clr_o = act.ilce_clr;
      end
   endgenerate

endmodule

// File: tb/chan_term_seq_tb_top.sv
module chan_term_seq_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] func_i = 3'b000;
   logic dir_out_i = 0, int_on_i = 0, zwc_en_i = 0, eor_en_i = 0;
   logic ilce_i = 0, buf_busy_i = 0;
   logic word_full_i = 0, wc_zero_i = 0, dev_eor_i = 0;
   logic buf_empty_i = 0, underrun_i = 0, top_req_i = 0;
   logic zwc_int_o, eow_int_o, eor_int_o, err_o, disc_o;
   logic wreor_o, xfr_drop_o, ilce_clr_o, interrec_o;

   localparam logic [8:0] Z  = 9'h100;
   localparam logic [8:0] W  = 9'h080;
   localparam logic [8:0] E  = 9'h040;
   localparam logic [8:0] ER = 9'h020;
   localparam logic [8:0] D  = 9'h010;
   localparam logic [8:0] WR = 9'h008;
   localparam logic [8:0] DR = 9'h004;
   localparam logic [8:0] C  = 9'h002;
   localparam logic [8:0] IR = 9'h001;
   localparam logic [8:0] NONE = 9'h000;

   localparam logic [2:0] F_COMP = 3'b000;
   localparam logic [2:0] F_RD   = 3'b100;
   localparam logic [2:0] F_RP   = 3'b101;
   localparam logic [2:0] F_SD   = 3'b110;
   localparam logic [2:0] F_SP   = 3'b111;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   logic [8:0] exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   chan_term_seq dut_i (
      .clk(clk), .rst_n(rst_n), .func_i(func_i), .dir_out_i(dir_out_i),
      .int_on_i(int_on_i), .zwc_en_i(zwc_en_i), .eor_en_i(eor_en_i),
      .ilce_i(ilce_i), .buf_busy_i(buf_busy_i), .word_full_i(word_full_i),
      .wc_zero_i(wc_zero_i), .dev_eor_i(dev_eor_i), .buf_empty_i(buf_empty_i),
      .underrun_i(underrun_i), .top_req_i(top_req_i),
      .zwc_int_o(zwc_int_o), .eow_int_o(eow_int_o), .eor_int_o(eor_int_o),
      .err_o(err_o), .disc_o(disc_o), .wreor_o(wreor_o),
      .xfr_drop_o(xfr_drop_o), .ilce_clr_o(ilce_clr_o), .interrec_o(interrec_o)
   );

   function automatic logic [8:0] outs();
      return {zwc_int_o, eow_int_o, eor_int_o, err_o, disc_o,
              wreor_o, xfr_drop_o, ilce_clr_o, interrec_o};
   endfunction

   task automatic compare(input logic [8:0] exp, input string tag);
      logic [8:0] act;
      act = outs();
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Driver: inputs already set at this negedge; record expectation, hold one cycle.
   task automatic cyc(input logic [8:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      word_full_i = 0; wc_zero_i = 0; dev_eor_i = 0;
      buf_empty_i = 0; underrun_i = 0; top_req_i = 0;
   endtask

   // Monitor: compares after each active edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 compare(NONE, "R1 reset state");
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cyc(NONE, "R1 idle after reset");

      // R2 input count zero
      dir_out_i = 0; zwc_en_i = 1; func_i = F_RD; wc_zero_i = 1;
      cyc(Z, "R2 input IORD count zero");
      func_i = F_COMP; wc_zero_i = 1;
      cyc(NONE, "R2 compatible count zero silent");
      cyc(NONE, "R1 pulse is single cycle");

      // R3
      func_i = F_SD; eor_en_i = 1; wc_zero_i = 1;
      cyc(Z | E | D, "R3 IOSD count zero with eor");
      eor_en_i = 0; wc_zero_i = 1;
      cyc(Z | D, "R3 IOSD count zero no eor");

      // R4
      func_i = F_COMP; int_on_i = 1; word_full_i = 1;
      cyc(W, "R4 compatible word full ints on");
      int_on_i = 0; word_full_i = 1;
      cyc(NONE, "R4 compatible word full ints off");
      func_i = F_SD; word_full_i = 1;
      cyc(ER, "R4 signal word full error");
      func_i = F_RD; int_on_i = 1; word_full_i = 1;
      cyc(NONE, "R4 record word full discarded");

      // R5
      func_i = F_RD; eor_en_i = 0; int_on_i = 1; dev_eor_i = 1;
      cyc(C | D, "R5 IORD eor no enable");
      func_i = F_COMP; dev_eor_i = 1;
      cyc(E | C | D, "R5 compatible eor ints on");
      int_on_i = 0; dev_eor_i = 1;
      cyc(C | D, "R5 compatible eor ints off");

      // R6
      func_i = F_RP; eor_en_i = 1; dev_eor_i = 1;
      cyc(E | C | IR, "R6 IORP enters inter-record");
      cyc(IR, "R6 inter-record held");
      eor_en_i = 0; word_full_i = 1;
      cyc(NONE, "R6 word full leaves inter-record");

      // R7
      dir_out_i = 1; func_i = F_COMP; int_on_i = 1; wc_zero_i = 1;
      cyc(Z | D, "R7 output compatible count zero");

      // R8
      func_i = F_SD; eor_en_i = 1; wc_zero_i = 1;
      cyc(Z | E | D, "R8 output IOSD count zero");
      func_i = F_SP; eor_en_i = 0; wc_zero_i = 1;
      cyc(Z | IR, "R8 output IOSP inter-record");
      buf_empty_i = 1;
      cyc(W, "R8 buffer empty clears inter-record");
      func_i = F_RD; wc_zero_i = 1;
      cyc(NONE, "R8 output IORD count zero silent");

      // R10
      buf_empty_i = 1;
      cyc(W, "R10 buffer empty ints on");
      ilce_i = 1; buf_empty_i = 1;
      cyc(NONE, "R10 buffer empty with interlace");
      ilce_i = 0; int_on_i = 0; buf_empty_i = 1;
      cyc(NONE, "R10 buffer empty ints off");

      // R9
      int_on_i = 1; buf_busy_i = 1; top_req_i = 1;
      cyc(NONE, "R9 terminate held pending");
      cyc(NONE, "R9 nothing while pending");
      buf_busy_i = 0; buf_empty_i = 1;
      cyc(WR, "R9 pending issues write eor");
      buf_empty_i = 1;
      cyc(W, "R9 pending cleared");
      top_req_i = 1;
      cyc(WR, "R9 idle terminate immediate");

      // R11
      underrun_i = 1;
      cyc(ER | DR, "R11 underrun");
      ilce_i = 1; underrun_i = 1;
      cyc(NONE, "R11 underrun interlace on");
      ilce_i = 0; func_i = F_RD; underrun_i = 1; dev_eor_i = 1;
      cyc(C | D, "R11 eor beats underrun");

      // R12
      dir_out_i = 0; top_req_i = 1;
      cyc(NONE, "R12 input terminate ignored");
      dir_out_i = 1; buf_empty_i = 1;
      cyc(W, "R12 no pending after input terminate");
      cyc(NONE, "R1 quiet end");

      @(posedge clk);
      #3;
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule